// File: doc/BRIEF.md
# Monochrome PAL Composite Sync and Video Generator

This block drives an 8-bit sample code into a resistor-ladder DAC to build a monochrome PAL composite signal, one progressive field at a time. A horizontal counter walks the clocks of a line and a vertical counter walks the lines of a field. A line-type state machine steps through short equalising pulses, broad vertical-sync pulses, blank lines and picture lines. Each new state is chosen at every half-line boundary.

The current line position, line number and an active-picture flag are presented to a separate address generator. That generator returns a 1-bit pixel in the same cycle. Inside the active picture the pixel selects white or black level. Everywhere else the pixel input is ignored and the code is either sync tip or blank level. With the default 50 MHz clock a line is 3200 clocks (64 µs) and a field is 312 lines.

Top module: `pal_cvbs_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `line_pos` and `line_num` become 0, `dac_code` becomes 77 and `active` is 0.
- R2: `line_pos` counts 0 to LINE_CLKS-1 and wraps to 0. `line_num` increments by one on each wrap of `line_pos`.
- R3: `dac_code` is registered. After a clock edge it is the code for the `line_pos`, `line_num` and `pixel_i` values present before that edge. It only ever takes the values 0 (sync), 77 (blank/black) or 255 (white).
- R4: Half-lines 0 to 4 of a field (half-line index = 2·line_num, plus 1 when line_pos ≥ LINE_CLKS/2) carry short pulses. The code is 0 for the first SHORT_W clocks of each half-line and 77 for the rest.
- R5: Half-lines 5 to 9 carry broad pulses. The code is 0 for the first BROAD_W clocks of each half-line and 77 for the rest.
- R6: Half-lines 10 to 14 carry short pulses, shaped as in R4.
- R7: From half-line 15 on, every line has exactly one sync pulse. It is 0 for line_pos below HSYNC_W and there is no pulse in the second half of the line. The second half of line 7 has no pulse at all.
- R8: `active` is 1 exactly when ACT_H0 ≤ line_pos < ACT_H1 and ACT_V0 ≤ line_num < ACT_V1.
- R9: Inside the active picture, `pixel_i`=1 gives 255 and `pixel_i`=0 gives 77. Outside it, `pixel_i` has no effect on `dac_code`.
- R10: After line LINES-1, `line_num` returns to 0 and the field sequence repeats unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| pixel_i | input | 1 | Pixel value from the address generator for the current position |
| dac_code | output | 8 | Level code for the resistor-ladder DAC |
| line_pos | output | HW | Clock position within the line |
| line_num | output | VW | Line number within the field |
| active | output | 1 | High inside the active picture region |

## Verification
A line-type state that has slipped by one half-line shows at the ports as a pulse of the wrong width or at the wrong place. Such a fault is visible within one half-line of the error, around the vertical-sync group. A counter that is off by one either moves every pulse edge or breaks the match between `line_pos` and `line_num` and an independent position model, on the next sample. The bench checks every sample of two full fields against a model built from the requirements. It also checks hand-computed spot values at the pulse and active-region edges.

// File: rtl/pal_cvbs_gen.sv
module pal_cvbs_gen #(
  parameter int LINE_CLKS = 3200,
  parameter int LINES     = 312,
  parameter int HSYNC_W   = 235,
  parameter int SHORT_W   = 118,
  parameter int BROAD_W   = 1365,
  parameter int ACT_H0    = 573,
  parameter int ACT_H1    = 2971,
  parameter int ACT_V0    = 16,
  parameter int ACT_V1    = 272,
  parameter int HW        = $clog2(LINE_CLKS),
  parameter int VW        = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pixel_i,
  output logic [7:0]    dac_code,
  output logic [HW-1:0] line_pos,
  output logic [VW-1:0] line_num,
  output logic          active
);
  localparam int HALF = LINE_CLKS / 2;
  localparam logic [7:0] LVL_SYNC  = 8'd0;
  localparam logic [7:0] LVL_BLANK = 8'd77;
  localparam logic [7:0] LVL_WHITE = 8'd255;

  typedef enum logic [1:0] {K_SHORT, K_BROAD, K_BLANK, K_DATA} kind_t;

  function automatic kind_t kind_of(input logic [VW:0] hl);
    logic [VW-1:0] v;
    v = hl[VW:1];
    if (hl < (VW+1)'(5))       return K_SHORT;
    else if (hl < (VW+1)'(10)) return K_BROAD;
    else if (hl < (VW+1)'(15)) return K_SHORT;
    else if (v >= VW'(ACT_V0) && v < VW'(ACT_V1)) return K_DATA;
    else return K_BLANK;
  endfunction

  kind_t         kind;
  logic          at_eol, at_eof, at_mid, second_half, sync;
  logic [HW-1:0] hpos;
  logic [VW-1:0] vnext;
  logic [7:0]    code_now;

  assign at_eol      = (line_pos == HW'(LINE_CLKS - 1));
  assign at_eof      = (line_num == VW'(LINES - 1));
  assign at_mid      = (line_pos == HW'(HALF - 1));
  assign second_half = (line_pos >= HW'(HALF));
  assign hpos        = second_half ? line_pos - HW'(HALF) : line_pos;
  assign vnext       = at_eof ? '0 : line_num + 1'b1;
  assign active      = (line_pos >= HW'(ACT_H0)) && (line_pos < HW'(ACT_H1)) &&
                       (line_num >= VW'(ACT_V0)) && (line_num < VW'(ACT_V1));

  always_comb begin
    case (kind)
      K_SHORT: sync = (hpos < HW'(SHORT_W));
      K_BROAD: sync = (hpos < HW'(BROAD_W));
      default: sync = !second_half && (line_pos < HW'(HSYNC_W));
    endcase
    if (sync)                   code_now = LVL_SYNC;
    else if (active && pixel_i) code_now = LVL_WHITE;
    else                        code_now = LVL_BLANK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_pos <= '0;
      line_num <= '0;
      kind     <= K_SHORT;
      dac_code <= LVL_BLANK;
    end else begin
      dac_code <= code_now;
      if (at_eol) begin
        line_pos <= '0;
        line_num <= vnext;
        kind     <= kind_of({vnext, 1'b0});
      end else begin
        line_pos <= line_pos + 1'b1;
        if (at_mid) kind <= kind_of({line_num, 1'b1});
      end
    end
  end

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    at_eol |=> (line_pos == '0));
  assert_field_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (at_eol && at_eof) |=> (line_num == '0));
  assert_code_set_R3: assert property (@(posedge clk) disable iff (rst)
    (dac_code == LVL_SYNC) || (dac_code == LVL_BLANK) || (dac_code == LVL_WHITE));
  assert_white_inside_R9: assert property (@(posedge clk) disable iff (rst)
    (dac_code == LVL_WHITE) |-> $past(active));
  assert_line_sync_R7: assert property (@(posedge clk) disable iff (rst)
    (kind == K_DATA && line_pos == '0) |=> (dac_code == LVL_SYNC));
  assert_broad_start_R5: assert property (@(posedge clk) disable iff (rst)
    (kind == K_BROAD && hpos == '0) |=> (dac_code == LVL_SYNC));
  assert_active_in_data_R8: assert property (@(posedge clk) disable iff (rst)
    active |-> (kind == K_DATA));
endmodule

// File: tb/pal_cvbs_gen_bench.sv
module pal_cvbs_gen_bench;
  localparam int CLK_PERIOD = 20;
  localparam int LC = 200, NL = 312, HS = 15, SW = 8, BW = 85;
  localparam int AH0 = 36, AH1 = 186, AV0 = 16, AV1 = 272;
  localparam int HALF = LC / 2;
  localparam int HW = $clog2(LC), VW = $clog2(NL);
  localparam int NT = 25;
  localparam int TV[NT] = '{0,0,0,0,2,2,2,2,4,5,7,7,8,8,8,16,16,16,16,16,17,17,271,272,311};
  localparam int TH[NT] = '{0,7,8,100,99,100,184,185,150,0,0,100,14,15,100,10,36,40,185,186,35,36,48,48,199};
  localparam int TC[NT] = '{0,0,77,0,77,0,0,77,0,0,0,77,0,77,77,0,77,255,255,77,77,255,255,77,77};

  logic clk = 0, rst = 1;
  logic pixel_i;
  logic [7:0] dac_code;
  logic [HW-1:0] line_pos;
  logic [VW-1:0] line_num;
  logic active;
  int checks = 0, fails = 0, cycles = 0;
  int eh = 0, ev = 0, ph = 0, pv = 0, ppix = 0;
  bit seen = 0, done = 0;

  pal_cvbs_gen #(.LINE_CLKS(LC), .LINES(NL), .HSYNC_W(HS), .SHORT_W(SW), .BROAD_W(BW),
    .ACT_H0(AH0), .ACT_H1(AH1), .ACT_V0(AV0), .ACT_V1(AV1)) u_pal_cvbs_gen (
    .clk(clk), .rst(rst), .pixel_i(pixel_i), .dac_code(dac_code),
    .line_pos(line_pos), .line_num(line_num), .active(active));

  assign pixel_i = line_pos[3] ^ line_num[0];
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int hl_of(int h, int v);
    return 2 * v + ((h >= HALF) ? 1 : 0);
  endfunction
  function automatic bit in_act(int h, int v);
    return h >= AH0 && h < AH1 && v >= AV0 && v < AV1;
  endfunction
  function automatic int model_code(int h, int v, int p);
    int hl = hl_of(h, v);
    int hp = h % HALF;
    if (hl < 5 || (hl >= 10 && hl < 15)) return (hp < SW) ? 0 : 77;
    if (hl < 10) return (hp < BW) ? 0 : 77;
    if (h < HS) return 0;
    return (in_act(h, v) && p != 0) ? 255 : 77;
  endfunction
  function automatic string tag_of(int h, int v);
    int hl = hl_of(h, v);
    if (hl < 5) return "R4";
    if (hl < 10) return "R5";
    if (hl < 15) return "R6";
    if (in_act(h, v)) return "R9";
    return "R7";
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (pos %0d line %0d)", tag, got, exp, eh, ev);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin eh <= 0; ev <= 0; seen <= 0; end
    else begin
      seen <= 1;
      if (eh == LC - 1) begin eh <= 0; ev <= (ev == NL - 1) ? 0 : ev + 1; end
      else eh <= eh + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && seen && !done) begin
      check((ev == 0) ? "R10" : "R2", int'(line_num), ev);
      check("R2", int'(line_pos), eh);
      check("R8", int'(active), int'(in_act(eh, ev)));
      check("R3", int'(dac_code == 0 || dac_code == 77 || dac_code == 255), 1);
      check(tag_of(ph, pv), int'(dac_code), model_code(ph, pv, ppix));
      for (int k = 0; k < NT; k++)
        if (pv == TV[k] && ph == TH[k]) check(tag_of(ph, pv), int'(dac_code), TC[k]);
    end
    ph <= eh; pv <= ev; ppix <= int'(pixel_i);
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(line_pos), 0);
    check("R1", int'(line_num), 0);
    check("R1", int'(dac_code), 77);
    check("R1", int'(active), 0);
    rst = 0;
    repeat (2 * LC * NL + 50) @(posedge clk);
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    check("R1", int'(line_pos), 0);
    check("R1", int'(line_num), 0);
    check("R1", int'(dac_code), 77);
    check("R1", int'(active), 0);
    rst = 0;
    repeat (3 * LC) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule